// File: doc/BRIEF.md
# Prefetch-Aware Cache Way Victim Selector

This block picks the way to fill or evict when a data cache miss occurs in a 16-way set-associative cache. It holds a 64-bit lockout register made of four 16-bit way masks, one per prefetch hint class. When a miss comes from a prefetch, the ways locked for that hint class are removed from the candidates. Demand misses always choose from all ways.

Among the eligible ways, the victim is chosen by a round-robin pointer kept for each set. The search starts at the pointer and moves forward, wrapping, to the first eligible way. The pointer moves past the chosen way only when an allocation happens. If a class locks every way, its prefetch misses are told not to allocate. This stops prefetched data from filling too much of the cache.

The victim and the no-allocate flag come out one cycle after the miss is presented. The tag store, data store and fill path sit outside this block.

Top module: `pf_victim_select`

## Requirements
- R1: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into the lockout register, and `cfg_rd_data` shows that value from the following cycle onward.
- R2: After reset the lockout register reads zero, every set's pointer is at way 0, and `vic_valid`, `vic_way` and `vic_no_alloc` are low.
- R3: The hint code selects the mask field: code 0 (NTA) uses bits 15:0, code 1 (T0) uses bits 31:16, code 2 (T1) uses bits 47:32, and code 3 (T2) uses bits 63:48. Bit k of a field stands for way k.
- R4: A prefetch miss never returns a way whose bit is set in the mask of its hint class.
- R5: When all 16 bits of the selected class mask are set, a prefetch miss returns `vic_no_alloc`=1 with `vic_way`=0, and that set's pointer does not move.
- R6: A demand miss (`miss_is_pf`=0) ignores every mask, chooses among all 16 ways, and never reports no-allocate.
- R7: The victim is the first eligible way found by searching from the set's pointer upward, wrapping from way 15 to way 0. After an allocation, the pointer becomes the victim index plus one, modulo 16.
- R8: Each set keeps its own pointer. A miss to one set leaves the pointers of all other sets unchanged.
- R9: A miss presented in cycle t gives `vic_valid`=1 together with its result in cycle t+1, and `vic_way` is one-hot when it allocates. In a cycle after no miss, all three result outputs are zero.
- R10: A register write affects misses presented in later cycles. A miss presented in the same cycle as a write uses the old masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Lockout register write strobe |
| cfg_wr_data | input | 64 | Value to load into the lockout register |
| cfg_rd_data | output | 64 | Current lockout register contents |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_is_pf | input | 1 | 1 = prefetch miss, 0 = demand miss |
| miss_hint | input | 2 | Prefetch hint class: 0 NTA, 1 T0, 2 T1, 3 T2 |
| miss_set | input | 6 | Set index of the miss |
| vic_valid | output | 1 | Result of the previous cycle's miss is valid |
| vic_way | output | 16 | One-hot victim way, zero when not allocating |
| vic_no_alloc | output | 1 | The prefetch miss must not allocate |

## Verification
The assertions assume `miss_is_pf` and `miss_hint` are known whenever `miss_valid` is high. They also assume reset is held for at least one clock before any miss, so every past value they sample comes from after reset. The bench drives all inputs to known values in every cycle, including the hint while a demand miss is presented. Its random phase mixes in register writes with fully locked fields, and it confines set indices to a few sets so that back-to-back misses to the same set exercise pointer forwarding.

// File: rtl/pf_victim_pkg.sv
// Package: shared constants and the hint-class encoding of the victim selector.
// Assumes four hint classes addressed by a 2-bit code.
package pf_victim_pkg;
    localparam int NUM_HINTS = 4;
    localparam int HINT_W    = $clog2(NUM_HINTS);

    typedef enum logic [HINT_W-1:0] {
        HINT_NTA = 2'd0,
        HINT_T0  = 2'd1,
        HINT_T1  = 2'd2,
        HINT_T2  = 2'd3
    } pf_hint_e;
endpackage

// File: rtl/pf_lock_regs.sv
// Module: holds the lockout register, one WAYS-bit field per hint class,
// field h occupying bits [h*WAYS +: WAYS]. Writes land at the clock edge.
// Assumes a synchronous active-low reset.
module pf_lock_regs #(
    parameter int WAYS  = 16,
    parameter int HINTS = 4,
    localparam int REG_W = WAYS * HINTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            rd_data,
    output logic [HINTS-1:0][WAYS-1:0]  masks
);
    logic [REG_W-1:0] lock_q;

    // Load the register on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= '0;
        else if (wr_en) lock_q <= wr_data;
    end

    assign rd_data = lock_q;

    // Slice the flat register into per-class masks.
    for (genvar h = 0; h < HINTS; h++) begin : g_field
        assign masks[h] = lock_q[h*WAYS +: WAYS];
    end

    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data == $past(wr_data));
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rd_data == '0);
endmodule

// File: rtl/pf_elig_mask.sv
// Module: turns the class masks into the set of ways a miss may fill.
// Prefetch misses exclude ways locked for their class; demand misses see all
// ways. Purely combinational.
module pf_elig_mask #(
    parameter int WAYS  = 16,
    parameter int HINTS = 4,
    localparam int HINT_W = $clog2(HINTS)
) (
    input  logic [HINTS-1:0][WAYS-1:0] masks,
    input  logic                       is_pf,
    input  logic [HINT_W-1:0]          hint,
    output logic [WAYS-1:0]            elig
);
    // Choose the class mask, invert it, or open every way on demand.
    always_comb begin
        if (is_pf) elig = ~masks[hint];
        else       elig = '1;
    end
endmodule

// File: rtl/pf_rr_pick.sv
// Module: round-robin search over eligible ways, starting at ptr and
// wrapping. Assumes WAYS is a power of two so index arithmetic wraps.
module pf_rr_pick #(
    parameter int WAYS = 16,
    localparam int PTR_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  elig,
    input  logic [PTR_W-1:0] ptr,
    output logic             found,
    output logic [PTR_W-1:0] way_idx,
    output logic [WAYS-1:0]  way_onehot
);
    logic [PTR_W-1:0] probe;

    // Walk forward from the pointer and keep the first eligible way.
    always_comb begin
        found   = 1'b0;
        way_idx = '0;
        probe   = '0;
        for (int i = 0; i < WAYS; i++) begin
            probe = ptr + PTR_W'(i);
            if (!found && elig[probe]) begin
                found   = 1'b1;
                way_idx = probe;
            end
        end
    end

    // Expand the chosen index to a one-hot vector.
    always_comb begin
        if (found) way_onehot = WAYS'(1) << way_idx;
        else       way_onehot = '0;
    end
endmodule

// File: rtl/pf_ptr_table.sv
// Module: one round-robin pointer per set, with a combinational read and a
// clocked write. A write becomes visible to reads in the next cycle.
module pf_ptr_table #(
    parameter int WAYS = 16,
    parameter int SETS = 64,
    localparam int PTR_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [PTR_W-1:0] rd_ptr,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [PTR_W-1:0] wr_ptr
);
    logic [PTR_W-1:0] ptr_q [SETS];

    // Clear every pointer on reset and update one set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (wr_en) begin
            ptr_q[wr_set] <= wr_ptr;
        end
    end

    assign rd_ptr = ptr_q[rd_set];

    p_ptr_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && rd_set == wr_set |=> rd_ptr == $past(wr_ptr) || rd_set != $past(wr_set));
endmodule

// File: rtl/pf_victim_select.sv
// Module: top of the victim selector. Combines the lockout register, the
// eligibility filter, the per-set pointers and the round-robin search. The
// result is registered, so it appears one cycle after the miss. Assumes
// WAYS and SETS are powers of two and that the hint is known during a miss.
module pf_victim_select
    import pf_victim_pkg::*;
#(
    parameter int WAYS = 16,
    parameter int SETS = 64,
    localparam int PTR_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS),
    localparam int REG_W = WAYS * NUM_HINTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             miss_valid,
    input  logic             miss_is_pf,
    input  logic [HINT_W-1:0] miss_hint,
    input  logic [SET_W-1:0] miss_set,
    output logic             vic_valid,
    output logic [WAYS-1:0]  vic_way,
    output logic             vic_no_alloc
);
    logic [NUM_HINTS-1:0][WAYS-1:0] masks;
    logic [WAYS-1:0]  elig;
    logic [PTR_W-1:0] cur_ptr;
    logic             found;
    logic [PTR_W-1:0] pick_idx;
    logic [WAYS-1:0]  pick_onehot;
    logic             alloc;

    pf_lock_regs #(.WAYS(WAYS), .HINTS(NUM_HINTS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .masks   (masks)
    );

    pf_elig_mask #(.WAYS(WAYS), .HINTS(NUM_HINTS)) u_elig (
        .masks (masks),
        .is_pf (miss_is_pf),
        .hint  (miss_hint),
        .elig  (elig)
    );

    pf_ptr_table #(.WAYS(WAYS), .SETS(SETS)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (miss_set),
        .rd_ptr (cur_ptr),
        .wr_en  (alloc),
        .wr_set (miss_set),
        .wr_ptr (pick_idx + PTR_W'(1))
    );

    pf_rr_pick #(.WAYS(WAYS)) u_pick (
        .elig       (elig),
        .ptr        (cur_ptr),
        .found      (found),
        .way_idx    (pick_idx),
        .way_onehot (pick_onehot)
    );

    // An allocation happens only for a presented miss that found a way.
    assign alloc = miss_valid && found;

    // Register the result so it appears in the cycle after the miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid    <= 1'b0;
            vic_way      <= '0;
            vic_no_alloc <= 1'b0;
        end else begin
            vic_valid    <= miss_valid;
            vic_way      <= miss_valid ? pick_onehot : '0;
            vic_no_alloc <= miss_valid && !found;
        end
    end

    p_locked_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid && !vic_no_alloc |-> (vic_way & ~$past(elig)) == '0);
    p_noalloc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vic_no_alloc |-> vic_valid && vic_way == '0);
    p_demand_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && !miss_is_pf |=> vic_valid && !vic_no_alloc);
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid && !vic_no_alloc |-> $onehot(vic_way));
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> vic_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> !vic_valid && vic_way == '0 && !vic_no_alloc);
endmodule

// File: tb/test_pf_victim_select.sv
// Bench: behavioural reference model (integer pointers per set, a plain
// 64-bit lock value) compared against the design on every clock.
module test_pf_victim_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic [63:0] cfg_rd_data;
    logic        miss_valid = 1'b0;
    logic        miss_is_pf = 1'b0;
    logic [1:0]  miss_hint = '0;
    logic [5:0]  miss_set = '0;
    logic        vic_valid;
    logic [15:0] vic_way;
    logic        vic_no_alloc;

    int errors = 0;
    int checks = 0;

    logic [63:0] m_lock = '0;
    int          m_ptr [64];
    logic        e_valid;
    logic [15:0] e_way;
    logic        e_na;

    always #10 clk = ~clk;

    pf_victim_select i_pf_victim_select (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .miss_valid(miss_valid), .miss_is_pf(miss_is_pf), .miss_hint(miss_hint),
        .miss_set(miss_set), .vic_valid(vic_valid), .vic_way(vic_way),
        .vic_no_alloc(vic_no_alloc)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, predict from model state, advance model, compare.
    task automatic step(input bit wr, input logic [63:0] wd, input bit mv,
                        input bit pf, input int h, input int s, input string tag);
        logic [15:0] ok;
        int          hit;
        cfg_wr_en   = wr;
        cfg_wr_data = wd;
        miss_valid  = mv;
        miss_is_pf  = pf;
        miss_hint   = 2'(h);
        miss_set    = 6'(s);
        e_valid = mv;
        e_way   = '0;
        e_na    = 1'b0;
        if (mv) begin
            ok  = pf ? ~m_lock[h*16 +: 16] : 16'hFFFF;
            hit = -1;
            for (int i = 0; i < 16; i++) begin
                if (hit < 0 && ok[(m_ptr[s] + i) % 16]) hit = (m_ptr[s] + i) % 16;
            end
            if (hit < 0) e_na = 1'b1;
            else begin
                e_way    = 16'(1) << hit;
                m_ptr[s] = (hit + 1) % 16;
            end
        end
        if (wr) m_lock = wd;
        @(posedge clk);
        #1;
        chk(tag, "vic_valid", 64'(vic_valid), 64'(e_valid));
        chk(tag, "vic_way", 64'(vic_way), 64'(e_way));
        chk(tag, "vic_no_alloc", 64'(vic_no_alloc), 64'(e_na));
        chk(tag, "cfg_rd_data", cfg_rd_data, m_lock);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, 1'b0, 0, 0, tag);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 64; s++) m_ptr[s] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R2: reset state at the ports
        chk("R2", "vic_valid", 64'(vic_valid), 64'd0);
        chk("R2", "vic_way", 64'(vic_way), 64'd0);
        chk("R2", "vic_no_alloc", 64'(vic_no_alloc), 64'd0);
        chk("R2", "cfg_rd_data", cfg_rd_data, 64'd0);
        rst_n = 1'b1;
        idle("R2");
        // R2/R6/R7: pointers start at way 0, demand misses step through ways
        step(0, '0, 1, 0, 0, 0, "R2");
        step(0, '0, 1, 0, 3, 0, "R7");
        step(0, '0, 1, 0, 1, 0, "R6");
        idle("R9");
        // R10: a miss in the write cycle uses the old masks
        step(1, 64'h0000_0000_0000_00FF, 1, 1, 0, 1, "R10");
        step(0, '0, 1, 1, 0, 1, "R10");
        step(0, '0, 1, 1, 0, 1, "R4");
        // R1/R3: distinct pattern per field, prefetch each class
        step(1, 64'hF0F0_FF00_0F0F_00FF, 0, 0, 0, 0, "R1");
        for (int h = 0; h < 4; h++) begin
            step(0, '0, 1, 1, h, 2, "R3");
            step(0, '0, 1, 1, h, 2, "R3");
        end
        // R5: fully locked T2 field blocks allocation, pointer holds
        step(1, 64'hFFFF_0000_0000_0000, 0, 0, 0, 0, "R1");
        step(0, '0, 1, 1, 3, 3, "R5");
        step(0, '0, 1, 1, 3, 3, "R5");
        step(0, '0, 1, 1, 0, 3, "R5");
        // R6: demand ignores every lock, even when all are full
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, i, 4, "R6");
        step(0, '0, 1, 1, 1, 4, "R5");
        // R7: wrap around from way 15 on one set
        step(1, 64'h0000_0000_0000_0000, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 18; i++) step(0, '0, 1, 0, 0, 5, "R7");
        step(1, 64'h0000_0000_0000_7FFE, 0, 0, 0, 0, "R1");
        step(0, '0, 1, 1, 0, 5, "R7");
        step(0, '0, 1, 1, 0, 5, "R7");
        // R8: interleaved sets keep separate pointers
        for (int i = 0; i < 6; i++) step(0, '0, 1, 0, 0, (i % 2) ? 9 : 10, "R8");
        // R4: random mix of writes and misses over a few sets
        for (int i = 0; i < 600; i++) begin
            logic [63:0] wd;
            wd = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) wd[$urandom_range(0, 3)*16 +: 16] = 16'hFFFF;
            step($urandom_range(0, 7) == 0, wd, $urandom_range(0, 4) != 0,
                 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, 3), "R4");
        end
        idle("R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule